// File: doc/BRIEF.md
# Third-Order Recursive Lowpass for Detector Pulses

This block smooths a stream of signed samples taken from a detector front end. It removes wideband additive noise before the pulse height is measured. The response is a third-order Butterworth lowpass built as a recursive filter. A single chain of state registers is used both by the recursion (poles) and by the output taps (zeros). The filter takes one sample each time the input strobe is high. It returns exactly one filtered sample for each accepted sample, after a fixed pipeline delay.

Samples and coefficients share one fixed-point format: two's complement, `DATA_W` bits wide, with `FRAC_W` of those bits after the binary point. The defaults are 12 and 10, so 1024 stands for 1.0 and the range is [-2.0, 2.0). The seven coefficients are elaboration parameters. The products are summed at full width. Both the intermediate state value and the output are rounded to nearest and clamped back to the sample width. The default coefficient set is a half-band design with DC gain close to one.

Top module: `iir3_lpf`

## Requirements
- R1: While the reset input is low, and afterwards until the first accepted sample has passed through, `out_valid` is 0 and `out_data` is 0. All state values start from zero, so the first output after reset equals round(B0·x/2^FRAC_W).
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` high, two clock edges later. Outputs come out in input order, and back-to-back input is supported.
- R3: In a cycle with `in_valid` low, `in_data` has no effect. The state is left as it was, and `out_data` holds its last value with `out_valid` low.
- R4: On each accepted sample x, the new state is s = sat(round(x·2^FRAC_W − A1·s1 − A2·s2 − A3·s3)). Here s1, s2 and s3 are the three most recent earlier states, newest first, and the state chain then shifts by one place.
- R5: The output for that sample is y = sat(round(B0·s + B1·s1 + B2·s2 + B3·s3)), using the state just computed and the three states before it.
- R6: Rounding divides by 2^FRAC_W to the nearest integer, with exact halves going toward +infinity. With default coefficients, a first input of 512 after reset yields 86.
- R7: Saturation clamps the state and the output to [−2^(DATA_W−1), 2^(DATA_W−1)−1], which is [−2048, 2047] by default, and never wraps.
- R8: The impulse response and the step response match the difference equations of R4 and R5 exactly, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | High when in_data carries a new sample |
| in_data | input | DATA_W | Signed input sample, FRAC_W fractional bits |
| out_valid | output | 1 | High for one cycle per filtered sample |
| out_data | output | DATA_W | Signed filtered sample, same format as input |

## Verification
A wrong value in any state register feeds back into every later sample. One corrupted state therefore shows at `out_data` on the output for the same sample, two edges after it was accepted, and it keeps ringing through all following outputs. An early shift, a lost hold or a misrouted tap makes the impulse response diverge within four samples. A rounding or clamping error appears at the ports only for tie values or overdriven patterns, so the bench drives those on purpose. It compares every output against an integer model of the equations.

// File: rtl/iir3_pkg.sv
package iir3_pkg;
  localparam int unsigned DEF_SAMPLE_W = 12;
  localparam int unsigned DEF_FRAC_W   = 10;
  localparam int unsigned FILT_ORDER   = 3;
  localparam int unsigned GUARD_W      = 3;

  typedef enum logic [0:0] {
    ACC_ADD = 1'b0,
    ACC_SUB = 1'b1
  } acc_sign_e;
endpackage

// File: rtl/iir3_rst_sync.sv
module iir3_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/iir3_mac.sv
module iir3_mac #(
  parameter int unsigned          DATA_W = 12,
  parameter int unsigned          TERMS  = 3,
  parameter int unsigned          ACC_W  = 27,
  parameter iir3_pkg::acc_sign_e  SIGN   = iir3_pkg::ACC_ADD
) (
  input  logic signed [DATA_W-1:0] coef_i [TERMS],
  input  logic signed [DATA_W-1:0] samp_i [TERMS],
  input  logic signed [ACC_W-1:0]  bias_i,
  output logic signed [ACC_W-1:0]  acc_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod     [TERMS];
  logic signed [ACC_W-1:0]  prod_ext [TERMS];
  logic signed [ACC_W-1:0]  acc_sum;

  for (genvar t = 0; t < TERMS; t++) begin : g_prod
    assign prod[t]     = PROD_W'(coef_i[t]) * PROD_W'(samp_i[t]);
    assign prod_ext[t] = ACC_W'(prod[t]);
  end

  always_comb begin
    acc_sum = bias_i;
    for (int t = 0; t < TERMS; t++) begin
      if (SIGN == iir3_pkg::ACC_SUB) begin
        acc_sum = acc_sum - prod_ext[t];
      end else begin
        acc_sum = acc_sum + prod_ext[t];
      end
    end
  end

  assign acc_o = acc_sum;
endmodule

// File: rtl/iir3_round_sat.sv
module iir3_round_sat #(
  parameter int unsigned ACC_W  = 27,
  parameter int unsigned FRAC_W = 10,
  parameter int unsigned OUT_W  = 12
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic signed [OUT_W-1:0] sat_o
);
  localparam int unsigned RW = ACC_W + 1;
  localparam logic signed [RW-1:0] HALF_R = RW'(1 << (FRAC_W - 1));
  localparam logic signed [RW-1:0] MAX_R  = RW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [RW-1:0] MIN_R  = RW'(-(1 << (OUT_W - 1)));

  logic signed [RW-1:0] biased;
  logic signed [RW-1:0] scaled;

  always_comb begin
    biased = RW'(acc_i) + HALF_R;
    scaled = biased >>> FRAC_W;
    if (scaled > MAX_R) begin
      sat_o = OUT_W'(MAX_R);
    end else if (scaled < MIN_R) begin
      sat_o = OUT_W'(MIN_R);
    end else begin
      sat_o = OUT_W'(scaled);
    end
  end
endmodule

// File: rtl/iir3_state_line.sv
module iir3_state_line #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en_i,
  input  logic signed [DATA_W-1:0] push_i,
  output logic signed [DATA_W-1:0] tap_o [DEPTH]
);
  logic signed [DATA_W-1:0] tap_q [DEPTH];
  logic signed [DATA_W-1:0] tap_d [DEPTH];

  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      if (s == 0) begin
        tap_d[s] = push_i;
      end else begin
        tap_d[s] = tap_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) begin
        tap_q[s] <= '0;
      end
    end else if (shift_en_i) begin
      for (int s = 0; s < DEPTH; s++) begin
        tap_q[s] <= tap_d[s];
      end
    end
  end

  assign tap_o = tap_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_chk
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en_i |=> (tap_q[s] == $past(tap_q[s]))); // R3
    if (s == 0) begin : g_head
      AST_LINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> (tap_q[0] == $past(push_i))); // R4
    end else begin : g_body
      AST_LINE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> (tap_q[s] == $past(tap_q[s-1]))); // R4
    end
  end
endmodule

// File: rtl/iir3_lpf.sv
module iir3_lpf #(
  parameter int unsigned DATA_W  = iir3_pkg::DEF_SAMPLE_W,
  parameter int unsigned FRAC_W  = iir3_pkg::DEF_FRAC_W,
  parameter int signed   COEF_B0 = 171,
  parameter int signed   COEF_B1 = 512,
  parameter int signed   COEF_B2 = 512,
  parameter int signed   COEF_B3 = 171,
  parameter int signed   COEF_A1 = 0,
  parameter int signed   COEF_A2 = 341,
  parameter int signed   COEF_A3 = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int unsigned ORDER = iir3_pkg::FILT_ORDER;
  localparam int unsigned TAPS  = ORDER + 1;
  localparam int unsigned ACC_W = 2 * DATA_W + iir3_pkg::GUARD_W;

  logic rst_i_n;

  iir3_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // coefficient vectors
  logic signed [DATA_W-1:0] fb_coef [ORDER];
  logic signed [DATA_W-1:0] ff_coef [TAPS];

  assign fb_coef[0] = DATA_W'(COEF_A1);
  assign fb_coef[1] = DATA_W'(COEF_A2);
  assign fb_coef[2] = DATA_W'(COEF_A3);
  assign ff_coef[0] = DATA_W'(COEF_B0);
  assign ff_coef[1] = DATA_W'(COEF_B1);
  assign ff_coef[2] = DATA_W'(COEF_B2);
  assign ff_coef[3] = DATA_W'(COEF_B3);

  // shared state chain: tap[0] newest
  logic signed [DATA_W-1:0] tap     [TAPS];
  logic signed [DATA_W-1:0] fb_samp [ORDER];
  logic signed [ACC_W-1:0]  fb_bias;
  logic signed [ACC_W-1:0]  fb_acc;
  logic signed [DATA_W-1:0] state_new;

  for (genvar k = 0; k < ORDER; k++) begin : g_fb_tap
    assign fb_samp[k] = tap[k];
  end

  assign fb_bias = ACC_W'(in_data) <<< FRAC_W;

  iir3_mac #(
    .DATA_W (DATA_W),
    .TERMS  (ORDER),
    .ACC_W  (ACC_W),
    .SIGN   (iir3_pkg::ACC_SUB)
  ) u_fb_mac (
    .coef_i (fb_coef),
    .samp_i (fb_samp),
    .bias_i (fb_bias),
    .acc_o  (fb_acc)
  );

  iir3_round_sat #(
    .ACC_W  (ACC_W),
    .FRAC_W (FRAC_W),
    .OUT_W  (DATA_W)
  ) u_fb_rs (
    .acc_i (fb_acc),
    .sat_o (state_new)
  );

  iir3_state_line #(
    .DATA_W (DATA_W),
    .DEPTH  (TAPS)
  ) u_line (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .shift_en_i (in_valid),
    .push_i     (state_new),
    .tap_o      (tap)
  );

  // feedforward taps read the registered chain one cycle later
  logic signed [ACC_W-1:0]  ff_acc;
  logic signed [DATA_W-1:0] y_sat;

  iir3_mac #(
    .DATA_W (DATA_W),
    .TERMS  (TAPS),
    .ACC_W  (ACC_W),
    .SIGN   (iir3_pkg::ACC_ADD)
  ) u_ff_mac (
    .coef_i (ff_coef),
    .samp_i (tap),
    .bias_i ('0),
    .acc_o  (ff_acc)
  );

  iir3_round_sat #(
    .ACC_W  (ACC_W),
    .FRAC_W (FRAC_W),
    .OUT_W  (DATA_W)
  ) u_ff_rs (
    .acc_i (ff_acc),
    .sat_o (y_sat)
  );

  // valid pipeline and output register
  logic                     stage_vld_q;
  logic                     stage_vld_d;
  logic                     out_vld_q;
  logic                     out_vld_d;
  logic signed [DATA_W-1:0] out_data_q;
  logic signed [DATA_W-1:0] out_data_d;

  always_comb begin
    stage_vld_d = in_valid;
    out_vld_d   = stage_vld_q;
    out_data_d  = out_data_q;
    if (stage_vld_q) begin
      out_data_d = y_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      stage_vld_q <= 1'b0;
      out_vld_q   <= 1'b0;
      out_data_q  <= '0;
    end else begin
      stage_vld_q <= stage_vld_d;
      out_vld_q   <= out_vld_d;
      out_data_q  <= out_data_d;
    end
  end

  assign out_valid = out_vld_q;
  assign out_data  = out_data_q;

  AST_STAGE_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_i_n)
    in_valid |=> stage_vld_q); // R2
  AST_STAGE_IDLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !in_valid |=> !stage_vld_q); // R3
  AST_OUT_TRACKS_STAGE: assert property (@(posedge clk) disable iff (!rst_i_n)
    stage_vld_q |=> out_valid); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    !stage_vld_q |=> (!out_valid && $stable(out_data))); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_i_n |-> (!out_valid && out_data == '0)); // R1
endmodule

// File: tb/iir3_lpf_tb_top.sv
module iir3_lpf_tb_top;
  localparam int DW = 12;
  localparam int FW = 10;
  localparam int B0 = 171;
  localparam int B1 = 512;
  localparam int B2 = 512;
  localparam int B3 = 171;
  localparam int A1 = 0;
  localparam int A2 = 341;
  localparam int A3 = 0;
  localparam int SMAX = 2047;
  localparam int SMIN = -2048;
  localparam int WATCHDOG = 150000;

  logic clk;
  logic rst_n;
  logic in_valid;
  logic signed [DW-1:0] in_data;
  logic out_valid;
  logic signed [DW-1:0] out_data;

  iir3_lpf #(
    .DATA_W(DW), .FRAC_W(FW),
    .COEF_B0(B0), .COEF_B1(B1), .COEF_B2(B2), .COEF_B3(B3),
    .COEF_A1(A1), .COEF_A2(A2), .COEF_A3(A3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seed   = 32'h1234_5678;
  bit done   = 1'b0;

  int    exp_q [$];
  int    cyc_q [$];
  string tag_q [$];
  string cur_tag = "R5";

  int m_s1 = 0;
  int m_s2 = 0;
  int m_s3 = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rsat(int acc);
    int r;
    r = (acc + (1 << (FW - 1))) >>> FW;
    if (r > SMAX) r = SMAX;
    if (r < SMIN) r = SMIN;
    return r;
  endfunction

  function automatic int model_step(int x);
    int s0;
    int y;
    s0 = rsat(x * (1 << FW) - A1 * m_s1 - A2 * m_s2 - A3 * m_s3);
    y  = rsat(B0 * s0 + B1 * m_s1 + B2 * m_s2 + B3 * m_s3);
    m_s3 = m_s2;
    m_s2 = m_s1;
    m_s1 = s0;
    return y;
  endfunction

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8);
  endfunction

  task automatic check(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(int x);
    in_valid = 1'b1;
    in_data  = DW'(x);
    exp_q.push_back(model_step(x));
    cyc_q.push_back(cyc);
    tag_q.push_back(cur_tag);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = DW'(rnd());
  endtask

  task automatic idle(int n);
    repeat (n) begin
      in_data = DW'(rnd());
      @(negedge clk);
    end
  endtask

  task automatic drain();
    idle(4);
    check("R2", exp_q.size(), 0, "pending outputs after drain");
  endtask

  // output monitor, samples on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R3", 1, 0, "out_valid with no accepted sample");
      end else begin
        check(tag_q[0], int'(out_data), exp_q[0], "filtered sample");
        check("R2", cyc - cyc_q[0], 2, "latency in edges");
        void'(exp_q.pop_front());
        void'(cyc_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    m_s1 = 0; m_s2 = 0; m_s3 = 0;
    idle(3);
    check("R1", int'(out_valid), 0, "out_valid in reset");
    check("R1", int'(out_data), 0, "out_data in reset");
    rst_n = 1'b1;
    idle(4);
    check("R1", int'(out_valid), 0, "out_valid after reset release");
    check("R1", int'(out_data), 0, "out_data after reset release");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    done = 1'b1;
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
    summary();
    $finish;
  end

  initial begin
    in_valid = 1'b0;
    in_data  = '0;
    rst_n    = 1'b0;
    @(negedge clk);
    do_reset();

    // R6 tie rounding on the first sample: 171*512/1024 = 85.5 -> 86
    cur_tag = "R6";
    push(512);
    idle(3);
    check("R6", int'(out_data), 86, "tie rounds upward");
    check("R1", int'(out_valid), 0, "single output only");
    push(0); push(0); push(0); push(0);
    drain();

    // R8 impulse response
    do_reset();
    cur_tag = "R8";
    push(1024);
    for (int i = 0; i < 30; i++) push(0);
    drain();

    // R8 step response, back to back
    for (int i = 0; i < 40; i++) push(1000);
    for (int i = 0; i < 40; i++) push(-700);
    drain();

    // R3 gapped stream with garbage on in_data while idle
    cur_tag = "R3";
    for (int i = 0; i < 300; i++) begin
      push((rnd() % 1500));
      idle((rnd() & 32'h3));
    end
    drain();

    // R7 overdriven pattern drives the state into clamping
    cur_tag = "R7";
    for (int i = 0; i < 60; i++) begin
      push(SMAX); push(SMAX); push(SMIN); push(SMIN);
    end
    for (int i = 0; i < 30; i++) push(SMAX);
    for (int i = 0; i < 30; i++) push(SMIN);
    drain();

    // R4 / R5 sweep every input code in a scrambled order
    cur_tag = "R4";
    for (int i = 0; i < 4096; i++) begin
      push(((i * 1237) % 4096) - 2048);
    end
    drain();

    // R5 fully random stream, then reset mid idle and recheck
    cur_tag = "R5";
    for (int i = 0; i < 500; i++) push((rnd() % 2048));
    drain();
    do_reset();
    cur_tag = "R1";
    push(-1024);
    for (int i = 0; i < 6; i++) push(0);
    drain();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule